// File: doc/BRIEF.md
# Configuration Security and Signature Controller

This block guards the non-volatile configuration store of a programmable device. A requester issues one command at a time: a bulk wipe, a program that closes selected connections in one configuration word, a verify read of one word, a seal that sets the security lock, and a read or write of one slice of an identification signature. Each accepted command runs for a fixed number of cycles and then returns one acknowledge pulse, with an error flag when it was refused. The configuration store is modelled as a small array of registers. A stored bit at 0 means the connection is open, which is the wiped state, and a bit at 1 means it is closed.

Once the lock is set, the configuration words can no longer be read or changed. Only a full wipe removes the lock, and the wipe also clears every configuration word and the signature. The signature can still be read while the lock is set, so a sealed device can still report which pattern it holds. The signature is 24 or 64 bits wide, chosen by a parameter. It is accessed in slices of one data word each.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset the block is idle and unlocked, with `ack`, `err` and `rd_data` at zero. Program and signature-write commands are refused until a wipe has completed.
- R2: A wipe (op code 0) takes WIPE_CYC cycles and is always granted. It returns every configuration word and every signature bit to 0, clears the lock, and enables programming.
- R3: A program (op code 1) takes BURN_CYC cycles. It ORs `req_data` into word `req_addr`. It is refused when `req_addr` is ROWS or above, when no wipe has happened since reset, or when any 1 bit of `req_data` is already 1 in the word. A refused program leaves the word unchanged.
- R4: A verify (op code 2) takes one cycle. When the block is unlocked and the address is below ROWS, it returns the stored word on `rd_data` in the cycle that `ack` is high.
- R5: A seal (op code 3) is always granted and sets the lock. A granted program issued with `req_seal` high also sets the lock when it completes.
- R6: While the lock is set, program, verify and signature-write commands are refused, and the configuration words and the signature stay unchanged.
- R7: A signature read (op code 4) is granted for any slice index below SIG_W/DATA_W, whether or not the lock is set. It returns signature bits [k*DATA_W+DATA_W-1 : k*DATA_W] for slice k. SIG_W is 24 when SIG_WIDE is 0 and 64 when SIG_WIDE is 1.
- R8: A signature write (op code 5) ORs `req_data` into slice `req_addr`. It is refused when the slice index is out of range, when the block is locked, when no wipe has happened since reset, or when a 1 bit of `req_data` is already set in the slice.
- R9: A refused command, including the unused op codes 6 and 7, raises `err` only in its single `ack` cycle and returns all zeros on `rd_data`.
- R10: Every accepted command produces exactly one `ack` pulse, one cycle long. `rd_data` is zero in every cycle without `ack`.
- R11: `busy` is high from the cycle after a request is accepted until its `ack` cycle. A request presented while `busy` is high is dropped: it produces no `ack` and has no effect.
- R12: Only a completed wipe clears the lock. Further seals and refused commands leave it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command request, sampled when idle |
| req_op | input | 3 | Op code: 0 wipe, 1 program, 2 verify, 3 seal, 4 signature read, 5 signature write |
| req_addr | input | ADDR_W | Word index, or signature slice index |
| req_data | input | DATA_W | Bits to close for a program or signature write |
| req_seal | input | 1 | Set the lock when this program completes |
| busy | output | 1 | A command is in progress |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | The completed command was refused |
| rd_data | output | DATA_W | Read result, valid with `ack` |
| locked | output | 1 | Security lock state |

## Verification
The embedded properties check on every cycle that:
- `ack` is a single-cycle pulse;
- `err` and non-zero read data never appear outside an `ack`;
- the latched command holds steady while busy;
- a wipe leaves no closed connection;
- no program ever tries to close an already closed bit;
- the lock falls only after a wipe;
- the signature is frozen while sealed;
- locked verifies are refused while signature reads stay open.

Only the bench scenarios can show the rest:
- the exact stored values after sequences of programs;
- that requests arriving while busy are truly dropped;
- that sealing through a program takes effect;
- that a wipe erases both the signature and the words.

// File: rtl/cfgsec_pkg.sv
// Package: shared op codes for the configuration guard.
// Assumes: op codes 6 and 7 are unused and are refused by the guard.
package cfgsec_pkg;

    typedef logic [2:0] op_t;

    localparam op_t OP_WIPE = 3'd0;
    localparam op_t OP_BURN = 3'd1;
    localparam op_t OP_READ = 3'd2;
    localparam op_t OP_SEAL = 3'd3;
    localparam op_t OP_IDRD = 3'd4;
    localparam op_t OP_IDWR = 3'd5;

endpackage

// File: rtl/cfg_op_sequencer.sv
// Module: cfg_op_sequencer
// Accepts one request while idle and latches it. It then counts the latency
// of that op and raises done for exactly one cycle at the end.
// Assumes: latencies are at least one cycle, and requests seen while busy are dropped.
module cfg_op_sequencer
    import cfgsec_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int WIPE_CYC = 4,
    parameter int BURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  op_t               req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_seal,
    output logic              busy,
    output logic              done,
    output op_t               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              seal_q
);

    localparam int MAX_LAT = (WIPE_CYC > BURN_CYC) ? WIPE_CYC : BURN_CYC;
    localparam int CNT_W   = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lat_m1;

    // Remaining cycles after the accept edge, per op.
    always_comb begin
        case (req_op)
            OP_WIPE: lat_m1 = CNT_W'(WIPE_CYC - 1);
            OP_BURN: lat_m1 = CNT_W'(BURN_CYC - 1);
            default: lat_m1 = '0;
        endcase
    end

    // Accept while idle, count down while busy, and release on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            op_q   <= OP_WIPE;
            addr_q <= '0;
            data_q <= '0;
            seal_q <= 1'b0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (req_valid) begin
            busy   <= 1'b1;
            cnt    <= lat_m1;
            op_q   <= req_op;
            addr_q <= req_addr;
            data_q <= req_data;
            seal_q <= req_seal;
        end
    end

    // Completion strobe for the latched op.
    assign done = busy && (cnt == '0);

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q))); // R11

endmodule

// File: rtl/cfg_fuse_array.sv
// Module: cfg_fuse_array
// Holds the configuration words. A wipe opens every connection (all bits 0).
// A program ORs new closed bits into one word.
// Assumes: the guard only asserts burn_en for an in-range word whose target bits are still open.
module cfg_fuse_array #(
    parameter int ROWS   = 6,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_en,
    input  logic              burn_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] burn_data,
    output logic [DATA_W-1:0] rd_word,
    output logic              any_closed
);

    logic [DATA_W-1:0] mem [ROWS];
    logic              in_rows;

    // Address range check for the single read/program port.
    assign in_rows = int'(addr) < ROWS;

    // Read port; out-of-range rows read as open.
    assign rd_word = in_rows ? mem[addr] : '0;

    // Wipe or program the store.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_en) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (burn_en && in_rows) begin
            mem[addr] <= mem[addr] | burn_data;
        end
    end

    // Summary of whether any connection anywhere is closed.
    always_comb begin
        any_closed = 1'b0;
        for (int r = 0; r < ROWS; r++) any_closed = any_closed | (|mem[r]);
    end

    AST_WIPE_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_en |=> !any_closed); // R2
    AST_BURN_CLOSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        burn_en |-> ((burn_data & rd_word) == '0)); // R3
    AST_ONE_STORE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wipe_en, burn_en})); // R3

endmodule

// File: rtl/cfg_lock_keeper.sv
// Module: cfg_lock_keeper
// Keeps the security lock, the wiped-since-reset flag and the signature.
// It decides whether the command completing now is granted, and forms its read value.
// Assumes: SIG_W is a multiple of DATA_W, and done is high for one cycle per command.
module cfg_lock_keeper
    import cfgsec_pkg::*;
#(
    parameter int ROWS   = 6,
    parameter int DATA_W = 8,
    parameter int SIG_W  = 24,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  op_t               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              seal,
    input  logic [DATA_W-1:0] cell_word,
    output logic              locked,
    output logic              grant,
    output logic              wipe_en,
    output logic              burn_en,
    output logic [DATA_W-1:0] rd_value
);

    localparam int SLICES = SIG_W / DATA_W;

    logic              prog_ok;
    logic [SIG_W-1:0]  sig;
    logic [DATA_W-1:0] sig_sl [SLICES];
    logic [DATA_W-1:0] sig_slice;
    logic              in_rows;
    logic              in_sig;

    // Slice view of the signature, one data word per slice.
    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        assign sig_sl[g] = sig[g*DATA_W +: DATA_W];
    end

    assign in_rows   = int'(addr) < ROWS;
    assign in_sig    = int'(addr) < SLICES;
    assign sig_slice = in_sig ? sig_sl[addr] : '0;

    // Permission decision and read value for the op at hand.
    always_comb begin
        grant    = 1'b0;
        rd_value = '0;
        case (op)
            OP_WIPE: grant = 1'b1;
            OP_BURN: grant = !locked && prog_ok && in_rows && ((data & cell_word) == '0);
            OP_READ: begin
                grant    = !locked && in_rows;
                rd_value = grant ? cell_word : '0;
            end
            OP_SEAL: grant = 1'b1;
            OP_IDRD: begin
                grant    = in_sig;
                rd_value = grant ? sig_slice : '0;
            end
            OP_IDWR: grant = !locked && prog_ok && in_sig && ((data & sig_slice) == '0);
            default: grant = 1'b0;
        endcase
    end

    // Store-side strobes for the array.
    assign wipe_en = done && (op == OP_WIPE);
    assign burn_en = done && grant && (op == OP_BURN);

    // Lock, programming permission and signature update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            prog_ok <= 1'b0;
            sig     <= '0;
        end else if (wipe_en) begin
            locked  <= 1'b0;
            prog_ok <= 1'b1;
            sig     <= '0;
        end else if (done && grant) begin
            if (op == OP_SEAL || (op == OP_BURN && seal)) locked <= 1'b1;
            if (op == OP_IDWR) begin
                for (int k = 0; k < SLICES; k++) begin
                    if (int'(addr) == k) sig[k*DATA_W +: DATA_W] <= sig[k*DATA_W +: DATA_W] | data;
                end
            end
        end
    end

    AST_LOCK_FALLS_ON_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(done && op == OP_WIPE)); // R12
    AST_SIG_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(sig)); // R6

endmodule

// File: rtl/cfg_guard_ctrl.sv
// Module: cfg_guard_ctrl (top)
// Configuration security and signature controller. A sequencer accepts commands.
// A lock keeper grants or refuses each one when it completes. A register array
// holds the configuration words. Results are registered into a single ack cycle.
// Assumes: one requester, and SIG_W (24 or 64) is a multiple of DATA_W.
module cfg_guard_ctrl
    import cfgsec_pkg::*;
#(
    parameter int  ROWS     = 6,
    parameter int  DATA_W   = 8,
    parameter bit  SIG_WIDE = 1'b0,
    parameter int  WIPE_CYC = 4,
    parameter int  BURN_CYC = 3,
    localparam int SIG_W    = SIG_WIDE ? 64 : 24,
    localparam int SLICES   = SIG_W / DATA_W,
    localparam int SPAN     = (ROWS > SLICES) ? ROWS : SLICES,
    localparam int ADDR_W   = (SPAN > 1) ? $clog2(SPAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_seal,
    output logic              busy,
    output logic              ack,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              locked
);

    logic              done;
    op_t               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              seal_q;
    logic              grant;
    logic              wipe_en;
    logic              burn_en;
    logic [DATA_W-1:0] cell_word;
    logic [DATA_W-1:0] rd_value;
    logic              any_closed;

    cfg_op_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIPE_CYC(WIPE_CYC), .BURN_CYC(BURN_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_seal(req_seal),
        .busy(busy), .done(done), .op_q(op_q), .addr_q(addr_q),
        .data_q(data_q), .seal_q(seal_q)
    );

    cfg_lock_keeper #(
        .ROWS(ROWS), .DATA_W(DATA_W), .SIG_W(SIG_W), .ADDR_W(ADDR_W)
    ) u_keep (
        .clk(clk), .rst_n(rst_n), .done(done), .op(op_q), .addr(addr_q),
        .data(data_q), .seal(seal_q), .cell_word(cell_word), .locked(locked),
        .grant(grant), .wipe_en(wipe_en), .burn_en(burn_en), .rd_value(rd_value)
    );

    cfg_fuse_array #(
        .ROWS(ROWS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_cells (
        .clk(clk), .rst_n(rst_n), .wipe_en(wipe_en), .burn_en(burn_en),
        .addr(addr_q), .burn_data(data_q), .rd_word(cell_word), .any_closed(any_closed)
    );

    // Register the completion result into one ack cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack     <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            ack     <= done;
            err     <= done && !grant;
            rd_data <= done ? rd_value : '0;
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10
    AST_QUIET_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rd_data == '0)); // R10
    AST_ERR_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack); // R9
    AST_REFUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_data == '0)); // R9
    AST_LOCKED_VERIFY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && locked && op_q == OP_READ) |=> err); // R6
    AST_SIG_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_IDRD && int'(addr_q) < SLICES) |=> !err); // R7

endmodule

// File: tb/cfg_guard_ctrl_test.sv
// Bench for cfg_guard_ctrl. A behavioural reference model runs beside the design
// and is compared on every clock. Directed scenarios add hand-computed checks.
module cfg_guard_ctrl_test;

    localparam int ROWS   = 6;
    localparam int SLICES = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [2:0] req_addr = 3'd0;
    logic [7:0] req_data = 8'd0;
    logic       req_seal = 1'b0;
    logic       busy, ack, err, locked;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done_run = 0;

    always #4 clk = ~clk;

    cfg_guard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_seal(req_seal),
        .busy(busy), .ack(ack), .err(err), .rd_data(rd_data), .locked(locked)
    );

    // ---------------- reference model ----------------
    int m_cells [ROWS];
    int m_sig [SLICES];
    bit m_lock, m_pok, m_busy, m_ack, m_err, m_seal;
    int m_cnt, m_op, m_addr, m_data, m_rd;

    task automatic model_complete();
        bit g = 0;
        int v = 0;
        case (m_op)
            0: begin
                g = 1;
                foreach (m_cells[i]) m_cells[i] = 0;
                foreach (m_sig[i]) m_sig[i] = 0;
                m_lock = 0;
                m_pok  = 1;
            end
            1: begin
                g = !m_lock && m_pok && m_addr < ROWS && ((m_addr < ROWS ? m_cells[m_addr] : 0) & m_data) == 0;
                if (g) begin
                    m_cells[m_addr] = m_cells[m_addr] | m_data;
                    if (m_seal) m_lock = 1;
                end
            end
            2: begin
                g = !m_lock && m_addr < ROWS;
                if (g) v = m_cells[m_addr];
            end
            3: begin
                g = 1;
                m_lock = 1;
            end
            4: begin
                g = m_addr < SLICES;
                if (g) v = m_sig[m_addr];
            end
            5: begin
                g = !m_lock && m_pok && m_addr < SLICES && ((m_addr < SLICES ? m_sig[m_addr] : 0) & m_data) == 0;
                if (g) m_sig[m_addr] = m_sig[m_addr] | m_data;
            end
            default: g = 0;
        endcase
        m_ack = 1;
        m_err = !g;
        m_rd  = g ? v : 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cells[i]) m_cells[i] = 0;
            foreach (m_sig[i]) m_sig[i] = 0;
            m_lock = 0; m_pok = 0; m_busy = 0; m_ack = 0; m_err = 0;
            m_cnt = 0; m_op = 0; m_addr = 0; m_data = 0; m_seal = 0; m_rd = 0;
        end else begin
            m_ack = 0; m_err = 0; m_rd = 0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0;
                    model_complete();
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end else if (req_valid) begin
                m_busy = 1;
                m_cnt  = (req_op == 3'd0) ? 3 : (req_op == 3'd1) ? 2 : 0;
                m_op   = int'(req_op);
                m_addr = int'(req_addr);
                m_data = int'(req_data);
                m_seal = req_seal;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            check("R10 ack", 64'(ack), 64'(m_ack));
            check("R9 err", 64'(err), 64'(m_err));
            check("R4 rd_data", 64'(rd_data), 64'(m_rd));
            check("R5 locked", 64'(locked), 64'(m_lock));
            check("R11 busy", 64'(busy), 64'(m_busy));
        end
    end

    task automatic run_cmd(input logic [2:0] op, input int a, input logic [7:0] d,
                           input logic s, output logic eo, output logic [7:0] ro);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = 3'(a); req_data = d; req_seal = s;
        @(negedge clk);
        req_valid = 1'b0; req_seal = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (ack) break;
            @(negedge clk);
        end
        eo = err;
        ro = rd_data;
    endtask

    task automatic finish_run();
        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic       e;
        logic [7:0] r;
        int         acks;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 0);
        check("R1 ack", 64'(ack), 0);
        check("R1 locked", 64'(locked), 0);
        check("R1 rd_data", 64'(rd_data), 0);

        run_cmd(3'd1, 0, 8'h01, 1'b0, e, r); check("R1 program before wipe refused", 64'(e), 1);
        run_cmd(3'd5, 0, 8'h01, 1'b0, e, r); check("R8 sig write before wipe refused", 64'(e), 1);
        run_cmd(3'd4, 0, 8'h00, 1'b0, e, r); check("R7 sig read granted", 64'(e), 0);

        run_cmd(3'd0, 0, 8'h00, 1'b0, e, r); check("R2 wipe granted", 64'(e), 0);
        for (int k = 0; k < ROWS; k++) begin
            run_cmd(3'd2, k, 8'h00, 1'b0, e, r); check("R2 word open after wipe", 64'(r), 0);
        end

        run_cmd(3'd1, 1, 8'h5A, 1'b0, e, r); check("R3 program granted", 64'(e), 0);
        run_cmd(3'd1, 1, 8'h0F, 1'b0, e, r); check("R3 closing a closed bit refused", 64'(e), 1);
        run_cmd(3'd1, 1, 8'h81, 1'b0, e, r); check("R3 program open bits", 64'(e), 0);
        run_cmd(3'd2, 1, 8'h00, 1'b0, e, r); check("R4 verify value", 64'(r), 64'hDB);
        run_cmd(3'd1, 6, 8'h01, 1'b0, e, r); check("R3 row out of range", 64'(e), 1);
        run_cmd(3'd2, 7, 8'h00, 1'b0, e, r); check("R9 refused read zero", 64'(r), 0);

        run_cmd(3'd5, 2, 8'hC3, 1'b0, e, r); check("R8 sig write granted", 64'(e), 0);
        run_cmd(3'd5, 2, 8'h01, 1'b0, e, r); check("R8 sig close-only refused", 64'(e), 1);
        run_cmd(3'd4, 2, 8'h00, 1'b0, e, r); check("R7 sig slice value", 64'(r), 64'h C3);
        run_cmd(3'd4, 3, 8'h00, 1'b0, e, r); check("R7 slice out of range", 64'(e), 1);
        run_cmd(3'd6, 0, 8'h00, 1'b0, e, r); check("R9 unused op refused", 64'(e), 1);

        // R11: a request arriving while busy is dropped
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = 3'd2; req_data = 8'h11;
        @(negedge clk);
        req_op = 3'd2; req_addr = 3'd1;
        @(negedge clk);
        req_valid = 1'b0;
        acks = 0;
        for (int i = 0; i < 8; i++) begin
            if (ack) acks++;
            @(negedge clk);
        end
        check("R11 one ack for two requests", 64'(acks), 1);
        run_cmd(3'd2, 2, 8'h00, 1'b0, e, r); check("R11 first request applied", 64'(r), 64'h11);

        run_cmd(3'd1, 3, 8'h22, 1'b1, e, r); check("R5 sealing program granted", 64'(e), 0);
        check("R5 lock set by program", 64'(locked), 1);
        run_cmd(3'd2, 3, 8'h00, 1'b0, e, r); check("R6 locked verify refused", 64'(e), 1);
        check("R6 locked verify zero", 64'(r), 0);
        run_cmd(3'd1, 4, 8'h01, 1'b0, e, r); check("R6 locked program refused", 64'(e), 1);
        run_cmd(3'd5, 0, 8'h01, 1'b0, e, r); check("R6 locked sig write refused", 64'(e), 1);
        run_cmd(3'd4, 2, 8'h00, 1'b0, e, r); check("R7 sig read while locked", 64'(r), 64'h C3);
        run_cmd(3'd3, 0, 8'h00, 1'b0, e, r); check("R12 seal again keeps lock", 64'(locked), 1);

        run_cmd(3'd0, 0, 8'h00, 1'b0, e, r); check("R12 wipe clears lock", 64'(locked), 0);
        run_cmd(3'd2, 3, 8'h00, 1'b0, e, r); check("R2 word cleared", 64'(r), 0);
        run_cmd(3'd4, 2, 8'h00, 1'b0, e, r); check("R2 signature cleared", 64'(r), 0);
        run_cmd(3'd3, 0, 8'h00, 1'b0, e, r); check("R5 seal command", 64'(locked), 1);
        run_cmd(3'd0, 0, 8'h00, 1'b0, e, r); check("R2 wipe after seal", 64'(locked), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule